// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block watches one asynchronous serial line and recovers data words from it. It runs on a system clock. The number of clocks per bit is set at elaboration from a clock-rate parameter and a baud-rate parameter. The line passes through a synchronizer and idles high. A falling edge opens a frame, and the cycle in which that edge is acted on becomes the time reference for every later sample. Each bit is sampled once, half a bit period plus a whole number of bit periods after that reference.

Three run-time inputs shape the frame: the data length (5 to 9 bits), the parity mode and the bit order. They are captured when a frame opens and stay fixed until it closes. When the stop bit is sampled, the block raises a one-cycle valid pulse and presents the assembled word. In the same cycle it raises three separate flags: start bit not low, parity mismatch, stop bit not high. A bad start bit does not end the frame. The receiver keeps collecting the data bits and reports the frame with that flag set. To monitor both directions of a link, place two copies of the block, one on each line.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, valid_o, start_err_o, parity_err_o and stop_err_o are 0 and word_o is all zeros.
- R2: While the line stays high, no frame is reported. A frame opens only on a high-to-low transition of the synchronized line.
- R3: With msb_first_i = 0, the first data bit received appears at word_o bit 0 and data bit k appears at bit k. Bits of word_o at and above the data length are 0.
- R4: With msb_first_i = 1, the first data bit received appears at word_o bit N-1, where N is the data length, and the last data bit appears at bit 0.
- R5: len_i selects the data length N, from 5 to 9 bits. A value below 5 is treated as 5 and a value above 9 is treated as 9.
- R6: par_i = 1 is odd parity and par_i = 2 is even parity. parity_err_o is set when the count of ones over the N data bits and the parity bit is even (odd mode) or odd (even mode).
- R7: par_i = 3 requires the parity bit to be 0 and par_i = 4 requires it to be 1. Any other parity bit value sets parity_err_o.
- R8: par_i = 0 (and the unused codes 5 to 7) means no parity bit. The stop bit is then the bit right after the last data bit, and parity_err_o stays 0.
- R9: stop_err_o is set when the stop-bit sample is 0. Only one stop bit is checked, and the receiver then waits for the next falling edge.
- R10: start_err_o is set when the start-bit sample is 1. The frame is still decoded through its data, parity and stop bits and reported.
- R11: valid_o is high for exactly one clock per frame, and every error flag is high only in that same clock.
- R12: Changes to len_i, par_i and msb_first_i after a frame has opened have no effect on that frame.
- R13: Bit n is sampled CPB/2 + n*CPB clocks after the reference cycle, where CPB = CLK_HZ/BAUD. The frame is reported one clock after the stop-bit sample. The stop bit index is N+1 without parity and N+2 with parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Serial line, idles high |
| len_i | input | LEN_W (4) | Data length select, 5 to MAX_LEN |
| par_i | input | 3 | Parity mode: 0 none, 1 odd, 2 even, 3 forced 0, 4 forced 1 |
| msb_first_i | input | 1 | 1 = first data bit is the most significant |
| valid_o | output | 1 | One-cycle pulse, frame finished |
| word_o | output | MAX_LEN (9) | Assembled data word, zero-extended |
| start_err_o | output | 1 | Start-bit sample was high (with valid_o) |
| parity_err_o | output | 1 | Parity check failed (with valid_o) |
| stop_err_o | output | 1 | Stop-bit sample was low (with valid_o) |

## Verification
Random frames cover every length, parity mode and bit order, with random data and with parity and stop bits corrupted at random. The word check separates the two shift directions, and the separate flag checks show that each fault is reported on its own. The cycle of the valid pulse is checked on every frame, so a parity slot wrongly inserted or wrongly skipped shows up as a timing miscompare even when the data matches. Directed frames add a two-clock low glitch that must produce a start error with an all-ones word, a configuration change in the middle of a frame, out-of-range length codes, and a long idle period.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      PAR_NONE = 3'd0,
      PAR_ODD  = 3'd1,
      PAR_EVEN = 3'd2,
      PAR_ZERO = 3'd3,
      PAR_ONE  = 3'd4
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } rx_state_e;

   // Decide whether a parity bit is wrong, given the xor of the data bits.
   function automatic logic parity_bad(par_mode_e mode, logic data_xor, logic pbit);
      case (mode)
         PAR_ODD:  return ~(data_xor ^ pbit);
         PAR_EVEN: return data_xor ^ pbit;
         PAR_ZERO: return pbit;
         PAR_ONE:  return ~pbit;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rx_line_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[0] <= 1'b1;
            else        chain_q[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain_q[i] <= 1'b1;
            else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];

   assign q_o    = chain_q[STAGES-1];
   assign fall_o = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
   parameter int CPB = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW   = $clog2(CPB);
   localparam int HALF = CPB / 2;
   localparam logic [CW-1:0] HALF_LD = CW'(HALF - 1);
   localparam logic [CW-1:0] FULL_LD = CW'(CPB - 1);

   logic [CW-1:0] cnt_q;

   if (CPB < 4) begin : g_bad_cpb
      $error("rx_bit_timer: at least 4 clocks per bit are needed");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               cnt_q <= '0;
      else if (arm_i)           cnt_q <= HALF_LD;
      else if (run_i) begin
         if (cnt_q == '0)       cnt_q <= FULL_LD;
         else                   cnt_q <= cnt_q - 1'b1;
      end

   assign tick_o = run_i && (cnt_q == '0);

   // R13
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_LD);

   // R13
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !arm_i) |=> !tick_o);

endmodule

// File: rtl/rx_word_shift.sv
module rx_word_shift #(
   parameter int DW = 9,
   parameter int LW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          shift_i,
   input  logic          bit_i,
   input  logic          msb_first_i,
   input  logic [LW-1:0] len_i,
   output logic [DW-1:0] word_o
);
   logic [DW-1:0] word_q, lsb_nxt, msb_nxt;
   logic [LW-1:0] top_idx;

   assign top_idx = len_i - 1'b1;

   always_comb begin
      lsb_nxt          = word_q >> 1;
      lsb_nxt[top_idx] = bit_i;
      msb_nxt          = {word_q[DW-2:0], bit_i};
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       word_q <= '0;
      else if (clr_i)   word_q <= '0;
      else if (shift_i) word_q <= msb_first_i ? msb_nxt : lsb_nxt;

   assign word_o = word_q;

   // R3
   lsb_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !clr_i && !msb_first_i) |=> word_q[$past(top_idx)] == $past(bit_i));

   // R4
   msb_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !clr_i && msb_first_i) |=> word_q[0] == $past(bit_i));

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
   import uart_rx_pkg::*;
#(
   parameter int CLK_HZ      = 100_000_000,
   parameter int BAUD        = 115_200,
   parameter int MAX_LEN     = 9,
   parameter int SYNC_STAGES = 2,
   parameter int LEN_W       = $clog2(MAX_LEN + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_i,
   input  logic [LEN_W-1:0]   len_i,
   input  logic [2:0]         par_i,
   input  logic               msb_first_i,
   output logic               valid_o,
   output logic [MAX_LEN-1:0] word_o,
   output logic               start_err_o,
   output logic               parity_err_o,
   output logic               stop_err_o
);
   localparam int CPB     = CLK_HZ / BAUD;
   localparam int MIN_LEN = 5;
   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_LEN);

   if (MAX_LEN < MIN_LEN) begin : g_bad_len
      $error("uart_frame_rx: MAX_LEN must be at least 5");
   end

   rx_state_e        state_q;
   logic             line_s, fall, tick, arm, run;
   logic [LEN_W-1:0] len_q, bitcnt_q, len_clamp;
   par_mode_e        par_q, par_in;
   logic             msb_q, xor_q, serr_q, perr_q;
   logic [MAX_LEN-1:0] shift_word;

   always_comb begin
      if (len_i < LEN_LO)      len_clamp = LEN_LO;
      else if (len_i > LEN_HI) len_clamp = LEN_HI;
      else                     len_clamp = len_i;
      par_in = (par_i > 3'd4) ? PAR_NONE : par_mode_e'(par_i);
   end

   assign arm = (state_q == ST_IDLE) && fall;
   assign run = (state_q != ST_IDLE);

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s), .fall_o(fall));

   rx_bit_timer #(.CPB(CPB)) u_timer (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .run_i(run), .tick_o(tick));

   rx_word_shift #(.DW(MAX_LEN), .LW(LEN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr_i(arm),
      .shift_i(tick && state_q == ST_DATA), .bit_i(line_s),
      .msb_first_i(msb_q), .len_i(len_q), .word_o(shift_word));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         len_q        <= LEN_HI;
         par_q        <= PAR_NONE;
         msb_q        <= 1'b0;
         bitcnt_q     <= '0;
         xor_q        <= 1'b0;
         serr_q       <= 1'b0;
         perr_q       <= 1'b0;
         valid_o      <= 1'b0;
         word_o       <= '0;
         start_err_o  <= 1'b0;
         parity_err_o <= 1'b0;
         stop_err_o   <= 1'b0;
      end else begin
         valid_o      <= 1'b0;
         start_err_o  <= 1'b0;
         parity_err_o <= 1'b0;
         stop_err_o   <= 1'b0;
         case (state_q)
            ST_IDLE: if (fall) begin
               len_q    <= len_clamp;
               par_q    <= par_in;
               msb_q    <= msb_first_i;
               bitcnt_q <= '0;
               xor_q    <= 1'b0;
               serr_q   <= 1'b0;
               perr_q   <= 1'b0;
               state_q  <= ST_START;
            end
            ST_START: if (tick) begin
               serr_q  <= line_s;
               state_q <= ST_DATA;
            end
            ST_DATA: if (tick) begin
               xor_q <= xor_q ^ line_s;
               if (bitcnt_q == len_q - 1'b1)
                  state_q <= (par_q == PAR_NONE) ? ST_STOP : ST_PAR;
               else
                  bitcnt_q <= bitcnt_q + 1'b1;
            end
            ST_PAR: if (tick) begin
               perr_q  <= parity_bad(par_q, xor_q, line_s);
               state_q <= ST_STOP;
            end
            ST_STOP: if (tick) begin
               valid_o      <= 1'b1;
               word_o       <= shift_word;
               start_err_o  <= serr_q;
               parity_err_o <= perr_q;
               stop_err_o   <= ~line_s;
               state_q      <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end

   // R11
   pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R11
   flags_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_err_o || parity_err_o || stop_err_o) |-> valid_o);

   // R2
   idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !fall) |=> state_q == ST_IDLE);

   // R12
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |->
         ($stable(len_q) && $stable(par_q) && $stable(msb_q)));

   // R5
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (len_q >= LEN_LO && len_q <= LEN_HI));

   // R8
   skip_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DATA && par_q == PAR_NONE) |=> state_q != ST_PAR);

endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
   localparam int BAUD = 115_200;
   localparam int CPB  = 16;
   localparam int HALF = CPB / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_i = 1'b1;
   logic [3:0] len_i = 4'd8;
   logic [2:0] par_i = 3'd0;
   logic       msb_first_i = 1'b0;
   logic       valid_o, start_err_o, parity_err_o, stop_err_o;
   logic [8:0] word_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   uart_frame_rx #(.CLK_HZ(BAUD * CPB), .BAUD(BAUD)) u_uart_frame_rx (
      .clk(clk), .rst_n(rst_n), .line_i(line_i), .len_i(len_i),
      .par_i(par_i), .msb_first_i(msb_first_i), .valid_o(valid_o),
      .word_o(word_o), .start_err_o(start_err_o),
      .parity_err_o(parity_err_o), .stop_err_o(stop_err_o));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [8:0] len_mask(input int len);
      return 9'((10'h1 << len) - 1);
   endfunction

   function automatic int eff_len(input int code);
      if (code < 5) return 5;
      if (code > 9) return 9;
      return code;
   endfunction

   function automatic logic good_pbit(input int par, input logic [8:0] d);
      case (par)
         1: return ~(^d);
         2: return ^d;
         4: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic pbit_wrong(input int par, input logic [8:0] d, input logic p);
      case (par)
         1: return ((^d) ^ p) == 1'b0;
         2: return ((^d) ^ p) == 1'b1;
         3: return p;
         4: return ~p;
         default: return 1'b0;
      endcase
   endfunction

   // One frame, driven and observed on falling clock edges.
   task automatic run_frame(input int len_code, input int par, input bit msb,
                            input logic [8:0] data, input bit bad_par,
                            input bit stop_v, input bit glitch, input bit cfg_swap,
                            input string tag);
      int len = eff_len(len_code);
      bit has_p = (par >= 1 && par <= 4);
      int nb = 1 + len + (has_p ? 1 : 0) + 1 + 2;
      logic bits [16];
      logic [8:0] d;
      logic p;
      int exp_k, seen_k, nvalid;
      logic [8:0] got_w;
      logic got_s, got_p, got_e;
      d = glitch ? len_mask(len) : (data & len_mask(len));
      p = glitch ? 1'b1 : (good_pbit(par, d) ^ bad_par);
      for (int i = 0; i < 16; i++) bits[i] = 1'b1;
      bits[0] = 1'b0;
      for (int i = 0; i < len; i++)
         bits[1 + i] = msb ? d[len - 1 - i] : d[i];
      if (has_p) bits[1 + len] = p;
      bits[1 + len + (has_p ? 1 : 0)] = glitch ? 1'b1 : stop_v;
      exp_k = 3 + HALF + CPB * (len + 1 + (has_p ? 1 : 0));
      seen_k = -1; nvalid = 0;
      got_w = '0; got_s = 0; got_p = 0; got_e = 0;
      for (int k = 0; k < nb * CPB; k++) begin
         @(negedge clk);
         if (valid_o) begin
            nvalid++;
            if (seen_k < 0) begin
               seen_k = k; got_w = word_o;
               got_s = start_err_o; got_p = parity_err_o; got_e = stop_err_o;
            end
         end else if (start_err_o || parity_err_o || stop_err_o) begin
            chk(0, {"R11 flag without valid ", tag}, 1, 0);
         end
         if (k == 0) begin
            len_i = 4'(len_code); par_i = 3'(par); msb_first_i = msb;
         end
         if (cfg_swap && k == 2 * CPB) begin
            len_i = (len == 9) ? 4'd5 : 4'd9;
            par_i = (par == 0) ? 3'd1 : 3'd0;
            msb_first_i = ~msb;
         end
         line_i = glitch ? (k >= 2) : bits[k / CPB];
      end
      chk(nvalid == 1, {"R11 valid pulse count ", tag}, nvalid, 1);
      chk(seen_k == exp_k, {"R13 report cycle ", tag}, seen_k, exp_k);
      chk(got_w == d, {msb ? "R4" : "R3", " word ", tag}, int'(got_w), int'(d));
      chk(got_s == glitch, {"R10 start flag ", tag}, got_s, glitch);
      chk(got_p == (has_p && pbit_wrong(par, d, p)),
          {has_p ? (par >= 3 ? "R7" : "R6") : "R8", " parity flag ", tag},
          got_p, (has_p && pbit_wrong(par, d, p)));
      chk(got_e == (!glitch && !stop_v), {"R9 stop flag ", tag},
          got_e, (!glitch && !stop_v));
   endtask

   initial begin
      #600000;
      chk(0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int nv;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(valid_o == 0 && start_err_o == 0 && parity_err_o == 0 && stop_err_o == 0,
          "R1 flags after reset", {valid_o, start_err_o, parity_err_o, stop_err_o}, 0);
      chk(word_o == '0, "R1 word after reset", int'(word_o), 0);
      rst_n = 1'b1;
      // R2 idle line
      nv = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (valid_o) nv++;
      end
      chk(nv == 0, "R2 idle line reports nothing", nv, 0);

      // Directed corner cases
      run_frame(8, 0, 0, 9'h0A5, 0, 1, 0, 0, "lsb8 none");
      run_frame(8, 0, 1, 9'h0A5, 0, 1, 0, 0, "msb8 none");
      run_frame(5, 1, 0, 9'h013, 0, 1, 0, 0, "R5 len5 odd");
      run_frame(9, 2, 1, 9'h1C3, 0, 1, 0, 0, "R5 len9 even");
      run_frame(7, 1, 0, 9'h055, 1, 1, 0, 0, "R6 odd bad");
      run_frame(6, 2, 1, 9'h02B, 1, 1, 0, 0, "R6 even bad");
      run_frame(8, 3, 0, 9'h0F0, 0, 1, 0, 0, "R7 zero ok");
      run_frame(8, 3, 0, 9'h0F0, 1, 1, 0, 0, "R7 zero bad");
      run_frame(8, 4, 1, 9'h00F, 0, 1, 0, 0, "R7 one ok");
      run_frame(8, 4, 1, 9'h00F, 1, 1, 0, 0, "R7 one bad");
      run_frame(8, 0, 0, 9'h03C, 0, 0, 0, 0, "R8 R9 none bad stop");
      run_frame(8, 6, 0, 9'h081, 0, 1, 0, 0, "R8 code6 is none");
      run_frame(7, 1, 0, 9'h000, 0, 1, 1, 0, "R10 glitch odd");
      run_frame(9, 2, 1, 9'h000, 0, 1, 1, 0, "R10 glitch even");
      run_frame(6, 1, 0, 9'h02D, 0, 1, 0, 1, "R12 cfg swap lsb");
      run_frame(9, 0, 1, 9'h15A, 0, 1, 0, 1, "R12 cfg swap msb");
      run_frame(2, 2, 0, 9'h1FF, 0, 1, 0, 0, "R5 len code 2");
      run_frame(15, 1, 1, 9'h1A6, 0, 1, 0, 0, "R5 len code 15");

      // Random frames
      for (int n = 0; n < 40; n++) begin
         int len = 5 + int'($urandom_range(4));
         int par = int'($urandom_range(4));
         bit msb = 1'($urandom_range(1));
         logic [8:0] d = 9'($urandom);
         bit bp = ($urandom_range(3) == 0);
         bit sv = ($urandom_range(6) != 0);
         run_frame(len, par, msb, d, bp, sv, 0, 0, "random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule